// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional buses, called A and B, and moves data between them in either direction. Each direction owns a storage register with a clock of its own. The A-to-B register samples bus A on a rising edge of `clk_ab`. The B-to-A register samples bus B on a rising edge of `clk_ba`. An active-low enable and a direction input choose which bus the block drives, if it drives either. For each direction, a select input chooses between two sources for the driven bus: the live value on the opposite bus, or the value held in that direction's register.

The control inputs decode into one of five output modes:

| Mode | Controls | Effect |
| --- | --- | --- |
| `XM_ISOLATE` | `oe_n`=1 | Neither bus is driven. |
| `XM_A2B_LIVE` | `oe_n`=0, `dir`=1, `sel_ab`=0 | B is driven with live A. |
| `XM_A2B_HELD` | `oe_n`=0, `dir`=1, `sel_ab`=1 | B is driven from the A-to-B register. |
| `XM_B2A_LIVE` | `oe_n`=0, `dir`=0, `sel_ba`=0 | A is driven with live B. |
| `XM_B2A_HELD` | `oe_n`=0, `dir`=0, `sel_ba`=1 | A is driven from the B-to-A register. |

The mode follows the control inputs with no clock in the path, so a new mode takes effect as soon as the inputs change. Capture does not depend on the mode. Either register, or both, can be loaded while the outputs are isolated. Each bus is modelled as an inout port with an enable-qualified driver.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge of `clk_ab` loads the value on `bus_a` into the A-to-B register. A rising edge of `clk_ba` loads the value on `bus_b` into the B-to-A register.
- R2: While `oe_n` is 1 (mode `XM_ISOLATE`), the block drives neither `bus_a` nor `bus_b`, so each bus carries only what an external source places on it.
- R3: While `oe_n` is 0, the driven bus is set by `dir`. With `dir`=1, `bus_b` is driven and `bus_a` is not. With `dir`=0, `bus_a` is driven and `bus_b` is not. The two buses are never driven together.
- R4: When `bus_b` is driven, `sel_ab`=0 places the live `bus_a` value on it (`XM_A2B_LIVE`). `sel_ab`=1 places the A-to-B register on it (`XM_A2B_HELD`).
- R5: When `bus_a` is driven, `sel_ba`=0 places the live `bus_b` value on it (`XM_B2A_LIVE`). `sel_ba`=1 places the B-to-A register on it (`XM_B2A_HELD`).
- R6: In `XM_ISOLATE`, each register captures on its own clock independently. One register can be loaded while the other keeps its value, or both can be loaded.
- R7: While the block drives one bus, the undriven bus can still be captured into its register. In held mode, the driven bus shows the new register value after that clock edge.
- R8: When `rst` is 1 at a rising edge of a register's clock, that register is cleared to 0x00, and the other register keeps its value.
- R9: The select input of the direction that is not driving has no effect on the driven bus.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled by each register's own clock |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive B from the A side. 0: drive A from the B side |
| sel_ab | input | 1 | Source for B. 0: live A. 1: stored A-to-B register |
| sel_ba | input | 1 | Source for A. 0: live B. 1: stored B-to-A register |
| bus_a | inout | 8 | Bidirectional bus A |
| bus_b | inout | 8 | Bidirectional bus B |

## Verification
At every edge of a register clock, the assertions check three things: that the register holds the bus value sampled at its previous edge, that isolation and direction gate the two drivers correctly, and that each driven bus equals the live or stored source chosen by its select. Several behaviours need the bench's stimulus sequences to show them. These are the independence of the two registers across isolation captures and mode changes, a stored value becoming visible only after a later mode switch, the select of the idle direction having no effect, and a reset that clears only the register whose clock edge saw it. The bench checks that there is no contention by driving the undriven bus itself and reading back its own value.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    parameter int BUS_W = 8;

    typedef enum logic [2:0] {
        XM_ISOLATE  = 3'd0,
        XM_A2B_LIVE = 3'd1,
        XM_A2B_HELD = 3'd2,
        XM_B2A_LIVE = 3'd3,
        XM_B2A_HELD = 3'd4
    } xmode_e;

endpackage

// File: rtl/rbx_capture_reg.sv
module rbx_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rbx_mode_decode.sv
module rbx_mode_decode
    import regbus_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    input  logic   sel_ab,
    input  logic   sel_ba,
    output xmode_e mode,
    output logic   drive_a,
    output logic   drive_b,
    output logic   use_held
);

    // Mode selection from the control pins.
    always_comb begin
        if (oe_n) begin
            mode = XM_ISOLATE;
        end else if (dir) begin
            mode = sel_ab ? XM_A2B_HELD : XM_A2B_LIVE;
        end else begin
            mode = sel_ba ? XM_B2A_HELD : XM_B2A_LIVE;
        end
    end

    // Per-mode driver enables and source choice.
    always_comb begin
        drive_a  = 1'b0;
        drive_b  = 1'b0;
        use_held = 1'b0;
        unique case (mode)
            XM_ISOLATE: begin
                drive_a  = 1'b0;
                drive_b  = 1'b0;
            end
            XM_A2B_LIVE: begin
                drive_b  = 1'b1;
            end
            XM_A2B_HELD: begin
                drive_b  = 1'b1;
                use_held = 1'b1;
            end
            XM_B2A_LIVE: begin
                drive_a  = 1'b1;
            end
            XM_B2A_HELD: begin
                drive_a  = 1'b1;
                use_held = 1'b1;
            end
            default: begin
                drive_a  = 1'b0;
                drive_b  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rbx_port_driver.sv
module rbx_port_driver #(
    parameter int W = 8
) (
    inout  wire  [W-1:0] pad,
    input  logic         en,
    input  logic [W-1:0] tx,
    output logic [W-1:0] rx
);

    assign pad = en ? tx : {W{1'bz}};
    assign rx  = pad;

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int WIDTH = regbus_pkg::BUS_W
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    inout  wire  [WIDTH-1:0] bus_a,
    inout  wire  [WIDTH-1:0] bus_b
);
    import regbus_pkg::*;

    xmode_e           mode;
    logic             drive_a;
    logic             drive_b;
    logic             use_held;
    logic [WIDTH-1:0] a_in;
    logic [WIDTH-1:0] b_in;
    logic [WIDTH-1:0] q_ab;
    logic [WIDTH-1:0] q_ba;
    logic [WIDTH-1:0] out_a;
    logic [WIDTH-1:0] out_b;

    rbx_mode_decode u_dec (
        .oe_n     (oe_n),
        .dir      (dir),
        .sel_ab   (sel_ab),
        .sel_ba   (sel_ba),
        .mode     (mode),
        .drive_a  (drive_a),
        .drive_b  (drive_b),
        .use_held (use_held)
    );

    rbx_capture_reg #(.W(WIDTH)) u_reg_ab (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (q_ab)
    );

    rbx_capture_reg #(.W(WIDTH)) u_reg_ba (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (q_ba)
    );

    // Live-or-stored source per direction.
    always_comb begin
        out_b = use_held ? q_ab : a_in;
        out_a = use_held ? q_ba : b_in;
    end

    rbx_port_driver #(.W(WIDTH)) u_pad_a (
        .pad (bus_a),
        .en  (drive_a),
        .tx  (out_a),
        .rx  (a_in)
    );

    rbx_port_driver #(.W(WIDTH)) u_pad_b (
        .pad (bus_b),
        .en  (drive_b),
        .tx  (out_b),
        .rx  (b_in)
    );

endmodule

// File: rtl/rbx_checker.sv
module rbx_checker #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] bus_a,
    input logic [W-1:0] bus_b,
    input logic         drive_a,
    input logic         drive_b,
    input logic [W-1:0] q_ab,
    input logic [W-1:0] q_ba
);

    p_capture_ab_r1: assert property (@(posedge clk_ab) disable iff (rst)
        !rst |=> q_ab == $past(bus_a));

    p_capture_ba_r1: assert property (@(posedge clk_ba) disable iff (rst)
        !rst |=> q_ba == $past(bus_b));

    p_isolate_r2: assert property (@(posedge clk_ab) disable iff (rst)
        oe_n |-> (!drive_a && !drive_b));

    p_dir_b_r3: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_n && dir) |-> (drive_b && !drive_a));

    p_dir_a_r3: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_n && !dir) |-> (drive_a && !drive_b));

    p_b_live_r4: assert property (@(posedge clk_ab) disable iff (rst)
        (drive_b && !sel_ab) |-> bus_b == bus_a);

    p_b_held_r4: assert property (@(posedge clk_ab) disable iff (rst)
        (drive_b && sel_ab) |-> bus_b == q_ab);

    p_a_live_r5: assert property (@(posedge clk_ba) disable iff (rst)
        (drive_a && !sel_ba) |-> bus_a == bus_b);

    p_a_held_r5: assert property (@(posedge clk_ba) disable iff (rst)
        (drive_a && sel_ba) |-> bus_a == q_ba);

endmodule

bind regbus_xcvr rbx_checker #(.W(WIDTH)) u_chk (
    .clk_ab  (clk_ab),
    .clk_ba  (clk_ba),
    .rst     (rst),
    .oe_n    (oe_n),
    .dir     (dir),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .bus_a   (a_in),
    .bus_b   (b_in),
    .drive_a (drive_a),
    .drive_b (drive_b),
    .q_ab    (q_ab),
    .q_ba    (q_ba)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       clk_ab = 1'b0;
    logic       clk_ba = 1'b0;
    logic       rst    = 1'b0;
    logic       oe_n   = 1'b1;
    logic       dir    = 1'b0;
    logic       sel_ab = 1'b0;
    logic       sel_ba = 1'b0;
    logic [7:0] tb_a   = 8'h00;
    logic [7:0] tb_b   = 8'h00;
    logic       tb_a_en = 1'b1;
    logic       tb_b_en = 1'b1;
    wire  [7:0] bus_a;
    wire  [7:0] bus_b;

    assign bus_a = tb_a_en ? tb_a : 8'bz;
    assign bus_b = tb_b_en ? tb_b : 8'bz;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    regbus_xcvr u0 (
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .rst    (rst),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .bus_a  (bus_a),
        .bus_b  (bus_b)
    );

    // Vector: [39]oe_n [38]dir [37]sel_ab [36]sel_ba [35]a_en [34]b_en
    //         [33]pulse clk_ab [32]pulse clk_ba [31:24]A [23:16]B
    //         [15:8]expected A [7:0]expected B
    localparam int NV = 15;
    localparam logic [39:0] VEC [0:NV-1] = '{
        {8'h8F, 8'h3C, 8'hC3, 8'h3C, 8'hC3},
        {8'h48, 8'h5A, 8'h00, 8'h5A, 8'h5A},
        {8'h68, 8'h11, 8'h00, 8'h11, 8'h3C},
        {8'h6A, 8'h77, 8'h00, 8'h77, 8'h77},
        {8'h04, 8'h00, 8'hE1, 8'hE1, 8'hE1},
        {8'h14, 8'h00, 8'h99, 8'hC3, 8'h99},
        {8'h15, 8'h00, 8'h42, 8'h42, 8'h42},
        {8'h4A, 8'hD4, 8'h00, 8'hD4, 8'hD4},
        {8'h68, 8'h00, 8'h00, 8'h00, 8'hD4},
        {8'h8E, 8'hF0, 8'h0F, 8'hF0, 8'h0F},
        {8'h14, 8'h00, 8'h66, 8'h42, 8'h66},
        {8'h68, 8'h01, 8'h00, 8'h01, 8'hF0},
        {8'h8D, 8'h12, 8'h34, 8'h12, 8'h34},
        {8'h14, 8'h00, 8'h00, 8'h34, 8'h00},
        {8'h58, 8'hAB, 8'h00, 8'hAB, 8'hAB}
    };
    localparam string VTAG [0:NV-1] = '{
        "R1 R2 R6", "R3 R4", "R4", "R7 R4", "R3 R5",
        "R5 R1", "R7 R5", "R7 R4", "R4 R1", "R6 R2",
        "R6 R5", "R6 R4", "R6 R2", "R6 R5", "R9 R4"
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit do_ab, input bit do_ba);
        #2;
        clk_ab = do_ab;
        clk_ba = do_ba;
        #2;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #2;
    endtask

    task automatic setup(input logic o, input logic d, input logic sa, input logic sb,
                         input logic ae, input logic be,
                         input logic [7:0] av, input logic [7:0] bv);
        oe_n = o; dir = d; sel_ab = sa; sel_ba = sb;
        tb_a_en = ae; tb_b_en = be; tb_a = av; tb_b = bv;
    endtask

    initial begin
        // Full reset: both registers cleared (R8).
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF);
        rst = 1'b1;
        pulse(1'b1, 1'b1);
        rst = 1'b0;
        setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55, 8'h00);
        #3;
        chk("R8 reset A-to-B", bus_b, 8'h00);
        setup(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hAA);
        #3;
        chk("R8 reset B-to-A", bus_a, 8'h00);

        // Vector walk.
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            setup(v[39], v[38], v[37], v[36], v[35], v[34], v[31:24], v[23:16]);
            pulse(v[33], v[32]);
            chk(VTAG[i], bus_a, v[15:8]);
            chk(VTAG[i], bus_b, v[7:0]);
        end

        // Registers now hold A-to-B=F0, B-to-A=34. Reset only the A-to-B side.
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88);
        rst = 1'b1;
        pulse(1'b1, 1'b0);
        rst = 1'b0;
        setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h09, 8'h00);
        #3;
        chk("R8 own-clock clear", bus_b, 8'h00);
        setup(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h09);
        #3;
        chk("R8 other kept", bus_a, 8'h34);

        // Reset only the B-to-A side.
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88);
        rst = 1'b1;
        pulse(1'b0, 1'b1);
        rst = 1'b0;
        setup(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h5C);
        #3;
        chk("R8 B-to-A clear", bus_a, 8'h00);

        // Idle select toggled in held B-to-A mode (R9).
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h5C);
        #3;
        chk("R9 sel_ab idle", bus_a, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule